// File: doc/BRIEF.md
# Oscillator Failure Detector

This block watches the timekeeping oscillator each time main power comes back. When the oscillator is enabled, it opens a fixed detection window that is counted in system-clock cycles. If no oscillator activity pulse arrives before the window closes, the block declares a failure. It then raises a sticky fail flag and issues a one-cycle request, which tells the time counter to reload from the stored base time. The block does not touch control settings, calibration settings or the enable bit.

The oscillator enable is active low: `osc_halt = 0` means the oscillator should be running, and this is the normal state. When `osc_halt = 1` at the moment power returns, no check is made. The host clears the flag by writing the flag bit as 0 while its write-enable bit is set. Any other write leaves the flag alone.

The window length is `WIN_CYC = CLK_HZ / 1_000_000 * WIN_US` cycles. The defaults give 5 ms at 125 MHz. The power-good input and the activity pulses are expected to be synchronous to `clk` already.

Top module: `osc_fail_monitor`

## Requirements
- R1: During and right after a synchronous reset (`rst_n` low), `osc_fail` and `restore_base` are 0.
- R2: Power return means `pwr_good` is sampled 1 at an edge after being 0 at the previous edge; call this the rise edge. If `osc_halt` is 0 at the rise edge and no `osc_tick` is sampled at the rise edge or at any of the next `WIN_CYC` edges, then `osc_fail` and `restore_base` both become 1 at the `WIN_CYC`-th edge after the rise edge.
- R3: An `osc_tick` sampled at any of the `WIN_CYC` edges after the rise edge ends the check with no failure.
- R4: If `osc_halt` is 1 at the rise edge, no check runs. No restore is issued and `osc_fail` keeps its value, whether that is 0 or 1.
- R5: `restore_base` is 1 for exactly one cycle per declared failure. A failure is also declared, with a new restore pulse, when the flag is already set.
- R6: Once set, `osc_fail` stays 1 through power loss. It also stays 1 through writes with `host_wr_gate` = 0 and through writes with `host_wr_data` = 1.
- R7: A write with `host_wr` = 1, `host_wr_gate` = 1 and `host_wr_data` = 0 clears `osc_fail` at that edge.
- R8: If a gated clear and a failure fall on the same edge, `osc_fail` ends up 1 and the restore pulse is still issued.
- R9: If `pwr_good` falls during the window, the check is abandoned with no failure. The next power return starts a fresh full window.
- R10: An `osc_tick` sampled at the rise edge itself counts as activity, so no window is opened.
- R11: `osc_halt` is sampled only at the rise edge. Changing it during an open window does not stop the check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that times the window |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Main power above the switch-over threshold |
| osc_halt | input | 1 | Nonvolatile oscillator enable, active low (1 = stopped) |
| osc_tick | input | 1 | One-cycle pulse for each observed oscillator cycle |
| host_wr | input | 1 | Host write strobe to the flag register |
| host_wr_gate | input | 1 | Host write-enable bit; writes to the flag count only while it is 1 |
| host_wr_data | input | 1 | Value written to the flag bit |
| osc_fail | output | 1 | Sticky oscillator-failure flag |
| restore_base | output | 1 | One-cycle request to reload time from the stored base time |

## Verification
Two functions can land on the same clock edge: the failure declaration that sets the flag, and a host clear that resets it. The bench provokes this by letting a failing window run while a gated zero-write is driven for exactly the closing edge of that window. The result is judged at the ports. The flag must read 1 afterwards and exactly one restore pulse must appear in the expected cycle. A neighbouring case checks that a tick on that same closing edge still counts as a pass.

// File: rtl/ofd_pkg.sv
// Package: shared types and helpers for the oscillator failure detector.
// Assumes: nothing beyond IEEE 1800-2017.
package ofd_pkg;

    // Window controller states
    typedef enum logic {
        WD_IDLE  = 1'b0,
        WD_WATCH = 1'b1
    } wd_state_e;

    // Convert a clock rate and a window in microseconds to a cycle count
    function automatic int win_cycles(input int clk_hz, input int win_us);
        return (clk_hz / 1_000_000) * win_us;
    endfunction

endpackage

// File: rtl/ofd_power_edge.sv
// Module: ofd_power_edge
// Detects a low-to-high change of the power-good level.
// Assumes: pwr_good is already synchronous to clk. After reset the previous
// value is taken as 0, so power that is already good counts as a return.
module ofd_power_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    output logic pwr_rise
);

    logic pwr_q;

    // Remember last cycle's power level
    always_ff @(posedge clk) begin
        if (!rst_n) pwr_q <= 1'b0;
        else        pwr_q <= pwr_good;
    end

    // Rise is the current level high with the previous level low
    always_comb pwr_rise = pwr_good && !pwr_q;

endmodule

// File: rtl/ofd_window_timer.sv
// Module: ofd_window_timer
// Opens a WIN_CYC-cycle watch after a power return while the oscillator is
// enabled, and flags the edge on which the window closes without activity.
// Assumes: osc_tick is a synchronous pulse; the enable is sampled at start only.
module ofd_window_timer #(
    parameter int WIN_CYC = 625_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic osc_halt,
    input  logic osc_tick,
    input  logic pwr_good,
    output logic fail_evt
);
    import ofd_pkg::*;

    localparam int CNT_W = $clog2(WIN_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYC - 1);

    wd_state_e        state;
    logic [CNT_W-1:0] cnt;

    // Failure: last window cycle, still powered, no activity seen
    always_comb fail_evt = (state == WD_WATCH) && pwr_good && !osc_tick && (cnt == LAST);

    // Window state and cycle count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WD_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                WD_IDLE: begin
                    if (start && !osc_halt && !osc_tick) begin
                        state <= WD_WATCH;
                        cnt   <= '0;
                    end
                end
                WD_WATCH: begin
                    if (!pwr_good || osc_tick || cnt == LAST) state <= WD_IDLE;
                    else                                      cnt   <= cnt + 1'b1;
                end
                default: state <= WD_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ofd_fail_flag.sv
// Module: ofd_fail_flag
// Holds the sticky failure flag and registers the one-cycle restore request.
// Assumes: a failure outranks a host clear on the same edge.
module ofd_fail_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic fail_evt,
    input  logic clr_req,
    output logic osc_fail,
    output logic restore_base
);

    // Sticky flag: set on failure, otherwise cleared by a gated write
    always_ff @(posedge clk) begin
        if (!rst_n)        osc_fail <= 1'b0;
        else if (fail_evt) osc_fail <= 1'b1;
        else if (clr_req)  osc_fail <= 1'b0;
    end

    // Restore request follows the failure event for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) restore_base <= 1'b0;
        else        restore_base <= fail_evt;
    end

endmodule

// File: rtl/osc_fail_monitor.sv
// Module: osc_fail_monitor (top)
// Checks after each power return that the timekeeping oscillator is alive.
// If it is not, the module sets a sticky flag and requests a base-time reload.
// Assumes: all inputs are synchronous to clk; CLK_HZ is a multiple of 1 MHz.
module osc_fail_monitor #(
    parameter int CLK_HZ = 125_000_000,
    parameter int WIN_US = 5_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic osc_halt,
    input  logic osc_tick,
    input  logic host_wr,
    input  logic host_wr_gate,
    input  logic host_wr_data,
    output logic osc_fail,
    output logic restore_base
);
    localparam int WIN_CYC = ofd_pkg::win_cycles(CLK_HZ, WIN_US);

    logic pwr_rise;
    logic fail_evt;
    logic clr_req;

    // Host clear only when writes are enabled and a zero is written
    always_comb clr_req = host_wr && host_wr_gate && !host_wr_data;

    ofd_power_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_good (pwr_good),
        .pwr_rise (pwr_rise)
    );

    ofd_window_timer #(.WIN_CYC(WIN_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (pwr_rise),
        .osc_halt (osc_halt),
        .osc_tick (osc_tick),
        .pwr_good (pwr_good),
        .fail_evt (fail_evt)
    );

    ofd_fail_flag u_flag (
        .clk          (clk),
        .rst_n        (rst_n),
        .fail_evt     (fail_evt),
        .clr_req      (clr_req),
        .osc_fail     (osc_fail),
        .restore_base (restore_base)
    );

endmodule

// File: rtl/ofd_checker.sv
// Module: ofd_checker
// Port-level properties for osc_fail_monitor, attached with bind.
// Assumes: WIN_CYC matches the top's window length.
module ofd_checker #(
    parameter int WIN_CYC = 625_000
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_good,
    input logic osc_halt,
    input logic osc_tick,
    input logic host_wr,
    input logic host_wr_gate,
    input logic host_wr_data,
    input logic osc_fail,
    input logic restore_base
);
    localparam int SW = $clog2(WIN_CYC + 2);
    localparam logic [SW-1:0] SAT = SW'(WIN_CYC + 1);

    logic          pq;
    logic          armed;
    logic [SW-1:0] since;
    logic          clr;

    always_comb clr = host_wr && host_wr_gate && !host_wr_data;

    // Independent model of the window: cycles since rise and still-armed status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pq    <= 1'b0;
            armed <= 1'b0;
            since <= SAT;
        end else begin
            pq <= pwr_good;
            if (pwr_good && !pq) begin
                since <= '0;
                armed <= !osc_halt && !osc_tick;
            end else if (!pwr_good) begin
                since <= SAT;
                armed <= 1'b0;
            end else begin
                if (since < SAT) since <= since + 1'b1;
                if (osc_tick)    armed <= 1'b0;
            end
        end
    end

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        restore_base |=> !restore_base);

    a_r5_restore_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        restore_base |-> osc_fail);

    a_r2_flag_rise_needs_restore: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_fail) |-> restore_base);

    a_r2_window_length: assert property (@(posedge clk) disable iff (!rst_n)
        restore_base |-> (since == SW'(WIN_CYC)));

    a_r3_armed_only: assert property (@(posedge clk) disable iff (!rst_n)
        restore_base |-> armed);

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_fail && !clr) |=> osc_fail);

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!osc_fail || restore_base));

endmodule

bind osc_fail_monitor ofd_checker #(.WIN_CYC(WIN_CYC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_good     (pwr_good),
    .osc_halt     (osc_halt),
    .osc_tick     (osc_tick),
    .host_wr      (host_wr),
    .host_wr_gate (host_wr_gate),
    .host_wr_data (host_wr_data),
    .osc_fail     (osc_fail),
    .restore_base (restore_base)
);

// File: tb/tb_osc_fail_monitor.sv
// Bench for osc_fail_monitor: a vector table walked by one loop, then
// directed tests for reset, stickiness, clearing and collisions.
module tb_osc_fail_monitor;

    localparam int CLK_HZ = 2_000_000;
    localparam int WIN_US = 5;
    localparam int WIN    = (CLK_HZ / 1_000_000) * WIN_US;
    localparam int NONE   = 255;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0;
    logic osc_halt = 1'b0;
    logic osc_tick = 1'b0;
    logic host_wr = 1'b0;
    logic host_wr_gate = 1'b0;
    logic host_wr_data = 1'b0;
    logic osc_fail;
    logic restore_base;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    osc_fail_monitor #(.CLK_HZ(CLK_HZ), .WIN_US(WIN_US)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_good     (pwr_good),
        .osc_halt     (osc_halt),
        .osc_tick     (osc_tick),
        .host_wr      (host_wr),
        .host_wr_gate (host_wr_gate),
        .host_wr_data (host_wr_data),
        .osc_fail     (osc_fail),
        .restore_base (restore_base)
    );

    // Vector fields: {halt, tick_at[7:0], expect_fail}
    localparam logic [9:0] VEC [6] = '{
        {1'b0, 8'd255, 1'b1},
        {1'b0, 8'd0,   1'b0},
        {1'b0, 8'd3,   1'b0},
        {1'b0, 8'd10,  1'b0},
        {1'b0, 8'd11,  1'b1},
        {1'b1, 8'd255, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic power_off();
        @(negedge clk);
        pwr_good = 1'b0;
        osc_tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Power return; iteration i drives edge E_i (E_0 is the rise edge)
    task automatic power_up(input logic halt, input int tick_at, input int clr_at,
                            input int drop_at, input int halt_at,
                            output int npulse, output int ppos);
        @(negedge clk);
        osc_halt = halt;
        pwr_good = 1'b1;
        osc_tick = (tick_at == 0);
        npulse = 0;
        ppos = -1;
        for (int i = 1; i <= WIN + 4; i++) begin
            @(negedge clk);
            if (restore_base) begin
                npulse++;
                ppos = i;
            end
            osc_tick     = (i == tick_at);
            host_wr      = (i == clr_at);
            host_wr_gate = (i == clr_at);
            host_wr_data = 1'b0;
            if (i == drop_at) pwr_good = 1'b0;
            if (i == halt_at) osc_halt = 1'b1;
        end
        osc_tick = 1'b0;
        host_wr = 1'b0;
        host_wr_gate = 1'b0;
        osc_halt = 1'b0;
    endtask

    task automatic host_write(input logic gate, input logic data);
        @(negedge clk);
        host_wr = 1'b1;
        host_wr_gate = gate;
        host_wr_data = data;
        @(negedge clk);
        host_wr = 1'b0;
        host_wr_gate = 1'b0;
        host_wr_data = 1'b0;
    endtask

    initial begin
        repeat (20_000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int np;
        int pp;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 osc_fail in reset", osc_fail, 0);
        chk("R1 restore_base in reset", restore_base, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 osc_fail after reset", osc_fail, 0);

        // Table walk
        for (int v = 0; v < 6; v++) begin
            logic halt;
            int   tat;
            logic expf;
            halt = VEC[v][9];
            tat  = int'(VEC[v][8:1]);
            expf = VEC[v][0];
            host_write(1'b1, 1'b0);
            power_off();
            power_up(halt, tat, 0, 0, 0, np, pp);
            if (halt) begin
                chk("R4 halted: restore count", np, 0);
                chk("R4 halted: flag", osc_fail, 0);
            end else if (expf) begin
                chk("R2 restore count", np, 1);
                chk("R2 restore position", pp, WIN + 1);
                chk("R2 flag set", osc_fail, 1);
            end else begin
                chk(tat == 0 ? "R10 tick at rise: restore count" : "R3 tick in window: restore count", np, 0);
                chk(tat == 0 ? "R10 tick at rise: flag" : "R3 tick in window: flag", osc_fail, 0);
            end
        end

        // R5: second failure while flag already set
        host_write(1'b1, 1'b0);
        power_off();
        power_up(1'b0, NONE, 0, 0, 0, np, pp);
        power_off();
        power_up(1'b0, NONE, 0, 0, 0, np, pp);
        chk("R5 repeat failure pulse count", np, 1);
        chk("R5 repeat failure flag", osc_fail, 1);

        // R6: sticky through power loss and ignored writes
        power_off();
        chk("R6 flag after power loss", osc_fail, 1);
        host_write(1'b0, 1'b0);
        chk("R6 flag after ungated write", osc_fail, 1);
        host_write(1'b1, 1'b1);
        chk("R6 flag after write of one", osc_fail, 1);

        // R4: halted return keeps a set flag
        power_up(1'b1, NONE, 0, 0, 0, np, pp);
        chk("R4 halted with flag set: pulses", np, 0);
        chk("R4 halted with flag set: flag", osc_fail, 1);

        // R7: gated clear
        host_write(1'b1, 1'b0);
        chk("R7 flag cleared", osc_fail, 0);

        // R8: clear on the failing edge
        power_off();
        power_up(1'b0, NONE, WIN, 0, 0, np, pp);
        chk("R8 collision pulse count", np, 1);
        chk("R8 collision flag", osc_fail, 1);

        // R9: power drop in window, then fresh window
        host_write(1'b1, 1'b0);
        power_off();
        power_up(1'b0, NONE, 0, 5, 0, np, pp);
        chk("R9 aborted window pulses", np, 0);
        chk("R9 aborted window flag", osc_fail, 0);
        power_up(1'b0, NONE, 0, 0, 0, np, pp);
        chk("R9 fresh window position", pp, WIN + 1);

        // R11: halt raised mid-window does not stop the check
        host_write(1'b1, 1'b0);
        power_off();
        power_up(1'b0, NONE, 0, 0, 3, np, pp);
        chk("R11 mid-window halt pulses", np, 1);
        chk("R11 mid-window halt flag", osc_fail, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule